// File: doc/BRIEF.md
# RGB Pixel to Word Stream Packer

The block takes a stream of RGB pixels, one pixel of three colour bytes per beat, and repacks it into a dense stream of 32-bit words for a memory writer. Each group of four pixels carries 96 bits of colour. That group leaves as three full words. Pixel bytes are never split across groups and never padded. A pixel source with valid/ready handshaking drives the input side. An AXI4-Stream style master port drives the output side, with data, byte keep, end-of-packet (last), frame start (user), valid and ready.

The input accepts one pixel per clock while `in_ready` is high. Of every four accepted pixels, the first is only held. Each of the other three completes a word, and that word is presented on the next clock. A transfer happens on either side only in a cycle where valid and ready are both high. Back-pressure from the sink reaches the source in the same cycle. While a word is waiting and `out_ready` is low, `in_ready` is low and the waiting word holds still.

A start-of-frame flag on a pixel becomes `out_user` on the word that holds that pixel's lowest byte. An end-of-line flag becomes `out_last` on the word that holds that pixel's highest byte. Lines are expected to be a multiple of four pixels, so a 640-pixel line ends exactly on its 480th word.

Top module: `rgb_word_packer`

## Requirements
- R1: A synchronous active-low reset clears any partly packed group and any pending word. In the cycle after reset is released, `out_valid` is 0 and `in_ready` is 1, and the next accepted pixel starts a new group.
- R2: A pixel is the 24-bit value {red, green, blue}, with blue in bits 7:0. Take the group's pixel bytes in order: for each pixel, blue, then green, then red. The packed stream is that byte sequence with 4 bytes per word, the earliest byte in bits 7:0. So word 0 = {p1[7:0], p0}, word 1 = {p2[15:0], p1[23:8]}, and word 2 = {p3, p2[23:16]}.
- R3: The first accepted pixel of a group produces no word. Accepting the second, third or fourth pixel of a group makes `out_valid` high on the following clock, with that pixel's word.
- R4: `in_ready` is 1 exactly when `out_ready` is 1 or `out_valid` is 0, so no pixel is taken while a word waits on a stalled sink.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_data`, `out_user` and `out_last` unchanged.
- R6: `out_user` is 1 on a word exactly when a pixel whose byte 0 lies in that word carried the start-of-frame flag. For example, the flag on pixel 0 or pixel 1 of a group marks word 0.
- R7: `out_last` is 1 on a word exactly when a pixel whose top byte lies in that word carried the end-of-line flag. For example, the flag on the fourth pixel of a group marks word 2.
- R8: `out_keep` is 4'b1111 on every valid word.
- R9: With random stalls on both sides, a 640-pixel line produces exactly 480 words, and `out_last` is on the 480th word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_red | input | COLOR_W (8) | Red component of the offered pixel |
| in_green | input | COLOR_W (8) | Green component |
| in_blue | input | COLOR_W (8) | Blue component |
| in_sof | input | 1 | Offered pixel is the first of a frame |
| in_eol | input | 1 | Offered pixel is the last of a line |
| in_valid | input | 1 | A pixel is offered |
| in_ready | output | 1 | The packer takes the offered pixel this cycle |
| out_data | output | 4*COLOR_W (32) | Packed word |
| out_keep | output | 4 | Byte enables, all set |
| out_last | output | 1 | Word ends a line packet |
| out_user | output | 1 | Word starts a frame |
| out_valid | output | 1 | A word is presented |
| out_ready | input | 1 | The sink takes the presented word |

## Verification
`in_ready` is combinational, so the bench checks it 1 ns after the inputs change in the same cycle. The packed word, its keep and its markers are due one clock after the accepting edge of the second, third or fourth pixel of a group. The bench drives at the falling edge and checks these at the next falling edge. A stalled word must stay unchanged from one falling edge to the next. A behavioural byte queue supplies the expected word, user and last values, and the bench compares them at each output handshake. The cycle right after reset is checked for an idle output and an open input.

// File: rtl/rwp_pkg.sv
`timescale 1ns/1ps
package rwp_pkg;
  // Position of the next accepted pixel inside its four-pixel group.
  typedef enum logic [1:0] {
    PH0 = 2'd0,
    PH1 = 2'd1,
    PH2 = 2'd2,
    PH3 = 2'd3
  } phase_e;

  localparam int unsigned GROUP_PIXELS = 4;
  localparam int unsigned GROUP_WORDS  = 3;
endpackage

// File: rtl/rwp_phase_ctr.sv
`timescale 1ns/1ps
module rwp_phase_ctr
  import rwp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH0;
    end else if (adv) begin
      unique case (phase)
        PH0: phase <= PH1;
        PH1: phase <= PH2;
        PH2: phase <= PH3;
        default: phase <= PH0;
      endcase
    end
  end
endmodule

// File: rtl/rwp_word_builder.sv
`timescale 1ns/1ps
module rwp_word_builder
  import rwp_pkg::*;
#(
  parameter int unsigned COLOR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  phase_e               phase,
  input  logic [3*COLOR_W-1:0] pix,
  output logic [4*COLOR_W-1:0] word
);
  localparam int unsigned PIX_W  = 3 * COLOR_W;
  localparam int unsigned WORD_W = 4 * COLOR_W;

  // Leftover bytes of the previous pixel, low-aligned.
  logic [PIX_W-1:0] carry_q;
  logic [PIX_W-1:0] carry_d;

  always_comb begin
    word    = '0;
    carry_d = '0;
    unique case (phase)
      PH0: begin
        carry_d = pix;
      end
      PH1: begin
        word    = {pix[COLOR_W-1:0], carry_q};
        carry_d = {{COLOR_W{1'b0}}, pix[PIX_W-1:COLOR_W]};
      end
      PH2: begin
        word    = {pix[2*COLOR_W-1:0], carry_q[2*COLOR_W-1:0]};
        carry_d = {{(2*COLOR_W){1'b0}}, pix[PIX_W-1:2*COLOR_W]};
      end
      default: begin
        word    = {pix, carry_q[COLOR_W-1:0]};
        carry_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= '0;
    end else if (load) begin
      carry_q <= carry_d;
    end
  end

  if (WORD_W != PIX_W + COLOR_W) begin : g_bad_width
    initial $error("word width must be four colour lanes");
  end
endmodule

// File: rtl/rwp_marker_align.sv
`timescale 1ns/1ps
module rwp_marker_align
  import rwp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  phase_e phase,
  input  logic   sof,
  input  logic   eol,
  output logic   word_user,
  output logic   word_last
);
  // A start flag goes with the word holding the pixel's low byte.
  // An end flag goes with the word holding the pixel's top byte.
  logic sof_q, eol_q;
  logic sof_d, eol_d;

  always_comb begin
    word_user = 1'b0;
    word_last = 1'b0;
    sof_d     = 1'b0;
    eol_d     = 1'b0;
    unique case (phase)
      PH0: begin
        sof_d = sof;
        eol_d = eol;
      end
      PH1: begin
        word_user = sof_q | sof;
        word_last = eol_q;
        eol_d     = eol;
      end
      PH2: begin
        word_user = sof;
        word_last = eol_q;
        eol_d     = eol;
      end
      default: begin
        word_user = sof;
        word_last = eol_q | eol;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sof_q <= 1'b0;
      eol_q <= 1'b0;
    end else if (load) begin
      sof_q <= sof_d;
      eol_q <= eol_d;
    end
  end
endmodule

// File: rtl/rwp_out_stage.sv
`timescale 1ns/1ps
module rwp_out_stage #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              word_user,
  input  logic              word_last,
  input  logic              sink_ready,
  output logic              can_take,
  output logic              q_valid,
  output logic [WORD_W-1:0] q_data,
  output logic              q_user,
  output logic              q_last
);
  assign can_take = !q_valid || sink_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_user  <= 1'b0;
      q_last  <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_data  <= word;
      q_user  <= word_user;
      q_last  <= word_last;
    end else if (sink_ready) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rgb_word_packer.sv
`timescale 1ns/1ps
module rgb_word_packer
  import rwp_pkg::*;
#(
  parameter int unsigned COLOR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [COLOR_W-1:0]   in_red,
  input  logic [COLOR_W-1:0]   in_green,
  input  logic [COLOR_W-1:0]   in_blue,
  input  logic                 in_sof,
  input  logic                 in_eol,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [4*COLOR_W-1:0] out_data,
  output logic [3:0]           out_keep,
  output logic                 out_last,
  output logic                 out_user,
  output logic                 out_valid,
  input  logic                 out_ready
);
  localparam int unsigned WORD_W = 4 * COLOR_W;

  phase_e              phase;
  logic                take;
  logic                emit;
  logic [WORD_W-1:0]   word;
  logic                word_user;
  logic                word_last;

  assign take = in_valid && in_ready;
  assign emit = take && (phase != PH0);

  rwp_phase_ctr u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take),
    .phase (phase)
  );

  rwp_word_builder #(.COLOR_W(COLOR_W)) u_build (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take),
    .phase (phase),
    .pix   ({in_red, in_green, in_blue}),
    .word  (word)
  );

  rwp_marker_align u_mark (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .phase     (phase),
    .sof       (in_sof),
    .eol       (in_eol),
    .word_user (word_user),
    .word_last (word_last)
  );

  rwp_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (emit),
    .word       (word),
    .word_user  (word_user),
    .word_last  (word_last),
    .sink_ready (out_ready),
    .can_take   (in_ready),
    .q_valid    (out_valid),
    .q_data     (out_data),
    .q_user     (out_user),
    .q_last     (out_last)
  );

  assign out_keep = 4'b1111;
endmodule

// File: rtl/rwp_checker.sv
`timescale 1ns/1ps
module rwp_checker #(
  parameter int unsigned COLOR_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_eol,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [4*COLOR_W-1:0] out_data,
  input logic                 out_user,
  input logic                 out_last
);
  // Independent count of accepted pixels within a group.
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 2'd0;
    else if (in_valid && in_ready) seen <= seen + 2'd1;
  end

  // R1: reset leaves no word pending
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_backpressure_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_user) && $stable(out_last)));

  p_word_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && seen != 2'd0) |=> out_valid);

  p_no_word_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && seen == 2'd0 && (!out_valid || out_ready)) |=> !out_valid);

  p_last_on_group_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && seen == 2'd3 && in_eol) |=> out_last);
endmodule

bind rgb_word_packer rwp_checker #(.COLOR_W(COLOR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eol    (in_eol),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_user  (out_user),
  .out_last  (out_last)
);

// File: tb/rgb_word_packer_tb_top.sv
`timescale 1ns/1ps
module rgb_word_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_red = '0, in_green = '0, in_blue = '0;
  logic        in_sof = 1'b0, in_eol = 1'b0, in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic        out_last, out_user, out_valid;
  logic        out_ready = 1'b0;

  always #2 clk = ~clk;

  rgb_word_packer #(.COLOR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
    .in_sof(in_sof), .in_eol(in_eol), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
    .out_user(out_user), .out_valid(out_valid), .out_ready(out_ready)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model: pending pixels, then a queue of packed bytes.
  logic [25:0] src_q[$];
  logic [7:0]  byte_q[$];
  bit          bsof_q[$];
  bit          beol_q[$];
  logic [33:0] cap_q[$];
  int          grp_pos = 0;
  bit          word_due = 0;
  bit          was_stall = 0;
  logic [33:0] stall_snap;
  int          line_words = 0;
  int          words_in_line = 0;
  int          lines_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_pix(input logic [23:0] rgb, input bit sof, input bit eol);
    src_q.push_back({sof, eol, rgb});
  endtask

  task automatic take_word();
    logic [31:0] ew;
    bit eu, el;
    if (byte_q.size() < 4) begin
      chk(0, "R3", "word with no complete bytes", {2'b0, out_data}, 34'h0);
      return;
    end
    ew = {byte_q[3], byte_q[2], byte_q[1], byte_q[0]};
    eu = bsof_q[0] | bsof_q[1] | bsof_q[2] | bsof_q[3];
    el = beol_q[0] | beol_q[1] | beol_q[2] | beol_q[3];
    repeat (4) begin
      void'(byte_q.pop_front()); void'(bsof_q.pop_front()); void'(beol_q.pop_front());
    end
    chk(out_data === ew, "R2", "packed word", {2'b0, out_data}, {2'b0, ew});
    chk(out_user === eu, "R6", "user marker", {33'b0, out_user}, {33'b0, eu});
    chk(out_last === el, "R7", "last marker", {33'b0, out_last}, {33'b0, el});
    cap_q.push_back({out_user, out_last, out_data});
    words_in_line++;
    if (out_last) begin
      if (line_words > 0)
        chk(words_in_line == line_words, "R9", "words per line",
            34'(words_in_line), 34'(line_words));
      lines_seen++;
      words_in_line = 0;
    end
  endtask

  task automatic tick(input int vpct, input int rpct);
    @(negedge clk);
    if (was_stall)
      chk(out_valid === 1'b1 && {out_user, out_last, out_data} === stall_snap,
          "R5", "stalled word changed", {out_user, out_last, out_data}, stall_snap);
    if (word_due)
      chk(out_valid === 1'b1, "R3", "word due after accept", {33'b0, out_valid}, 34'h1);
    in_valid = (src_q.size() > 0) && (int'($urandom_range(99)) < vpct);
    if (src_q.size() > 0) begin
      {in_sof, in_eol, in_red, in_green, in_blue} = src_q[0];
    end
    out_ready = int'($urandom_range(99)) < rpct;
    #1;
    chk(in_ready === (out_ready || !out_valid), "R4", "in_ready back-pressure",
        {33'b0, in_ready}, {33'b0, (out_ready || !out_valid)});
    if (out_valid)
      chk(out_keep === 4'hF, "R8", "keep", {30'b0, out_keep}, 34'hF);
    was_stall  = out_valid && !out_ready;
    stall_snap = {out_user, out_last, out_data};
    if (out_valid && out_ready) take_word();
    word_due = 0;
    if (in_valid && in_ready) begin
      logic [25:0] p;
      p = src_q.pop_front();
      byte_q.push_back(p[7:0]);   bsof_q.push_back(p[25]); beol_q.push_back(1'b0);
      byte_q.push_back(p[15:8]);  bsof_q.push_back(1'b0);  beol_q.push_back(1'b0);
      byte_q.push_back(p[23:16]); bsof_q.push_back(1'b0);  beol_q.push_back(p[24]);
      word_due = (grp_pos != 0);
      grp_pos  = (grp_pos + 1) % 4;
    end
  endtask

  task automatic run_until_empty(input int vpct, input int rpct);
    int guard = 0;
    while ((src_q.size() > 0 || byte_q.size() >= 4 || out_valid) && guard < 50000) begin
      tick(vpct, rpct);
      guard++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    src_q.delete(); byte_q.delete(); bsof_q.delete(); beol_q.delete(); cap_q.delete();
    grp_pos = 0; word_due = 0; was_stall = 0; words_in_line = 0;
    #1;
    // R1: idle output, open input right after reset
    chk(out_valid === 1'b0, "R1", "out_valid after reset", {33'b0, out_valid}, 34'h0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", {33'b0, in_ready}, 34'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2 layout with fixed pixels, R6/R7 on group edges
    push_pix(24'hA1B2C3, 1, 0);
    push_pix(24'hD4E5F6, 0, 0);
    push_pix(24'h112233, 0, 0);
    push_pix(24'h445566, 0, 1);
    run_until_empty(100, 100);
    chk(cap_q.size() == 3, "R3", "three words per group", 34'(cap_q.size()), 34'd3);
    if (cap_q.size() == 3) begin
      chk(cap_q[0] === {2'b10, 32'hF6A1B2C3}, "R2", "word0 layout", cap_q[0], {2'b10, 32'hF6A1B2C3});
      chk(cap_q[1] === {2'b00, 32'h2233D4E5}, "R2", "word1 layout", cap_q[1], {2'b00, 32'h2233D4E5});
      chk(cap_q[2] === {2'b01, 32'h44556611}, "R7", "word2 last", cap_q[2], {2'b01, 32'h44556611});
    end

    // R6/R7 mid-group markers: start flag on pixel 2, end flag on pixel 1
    cap_q.delete();
    push_pix(24'h010203, 0, 0);
    push_pix(24'h040506, 0, 1);
    push_pix(24'h070809, 1, 0);
    push_pix(24'h0A0B0C, 0, 0);
    run_until_empty(70, 50);
    if (cap_q.size() == 3) begin
      chk(cap_q[0][33:32] === 2'b00, "R6", "word0 unmarked", {32'b0, cap_q[0][33:32]}, 34'h0);
      chk(cap_q[1][33:32] === 2'b11, "R6", "word1 user and last", {32'b0, cap_q[1][33:32]}, 34'h3);
    end else chk(0, "R3", "mid-group word count", 34'(cap_q.size()), 34'd3);

    // R1: reset in the middle of a group restarts packing
    push_pix(24'hFFEEDD, 0, 0);
    push_pix(24'hCCBBAA, 0, 0);
    while (src_q.size() > 0) tick(100, 100);
    tick(0, 100);
    do_reset();
    push_pix(24'hA1B2C3, 0, 0);
    push_pix(24'hD4E5F6, 0, 0);
    push_pix(24'h112233, 0, 0);
    push_pix(24'h445566, 0, 0);
    run_until_empty(100, 100);
    if (cap_q.size() >= 1)
      chk(cap_q[0][31:0] === 32'hF6A1B2C3, "R1", "fresh group after reset",
          {2'b0, cap_q[0][31:0]}, {2'b0, 32'hF6A1B2C3});
    else chk(0, "R1", "no word after reset", 34'h0, 34'h1);

    // R9: three 640-pixel lines under random stalls on both sides
    line_words = 480; lines_seen = 0; words_in_line = 0;
    for (int ln = 0; ln < 3; ln++)
      for (int px = 0; px < 640; px++)
        push_pix(24'($urandom), (ln == 0 && px == 0), (px == 639));
    run_until_empty(80, 60);
    chk(lines_seen == 3, "R9", "lines completed", 34'(lines_seen), 34'd3);
    chk(byte_q.size() == 0, "R9", "model drained", 34'(byte_q.size()), 34'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule